// File: doc/BRIEF.md
# Timer Output-Compare Channel with Software Forcing

This block is a single output-compare channel that sits beside a free-running timer counter. It compares the counter value with a shadow compare value and drives an internal reference waveform, which is always active-high. It also drives a pin whose polarity software selects. The reference follows one of several compare actions: freeze, set on match, clear on match, or toggle on match. Software can also force it to a fixed high or low level.

While the reference is forced, the comparison keeps running. A match still raises the sticky compare flag and, when enabled, the interrupt request. Software can therefore hold the pin at a safe level and still track counter timing.

A compare value is written through a buffer register. With preload enabled, the buffer moves into the shadow value at the next counter update event. With preload disabled, the write goes straight into the shadow value. The channel acts as an output only while its direction field is 00.

Top module: `oc_channel`

## Requirements
- R1: While `rst` is high at a clock edge, the channel resets. After that edge, `ref_o`, `flag_o` and `irq_o` are 0, the shadow compare value is 0, and `pin_o` equals `pol_i`.
- R2: With `preload_en_i` low, a write (`cmp_wr_i` high) loads `cmp_wdata_i` into the shadow value at that clock edge.
- R3: With `preload_en_i` high, a write only fills the buffer. The shadow value takes the buffer content at an edge where `upd_evt_i` is high. A write at that same edge lands in the buffer and reaches the shadow value at the following update event.
- R4: A match happens at an edge where `dir_sel_i` is 00, `cnt_i` equals the shadow value, and the two were not equal at the previous edge. The reference reacts at that same edge. The "were equal" history is 1 after reset.
- R5: `mode_i` 001 sets the reference to 1 on a match, 010 clears it to 0 on a match, and 011 inverts it on a match. Without a match, the reference holds.
- R6: `mode_i` 000, 110 and 111 hold the reference at its present level whatever the comparison does.
- R7: `mode_i` 101 drives the reference to 1 and `mode_i` 100 drives it to 0 at the next edge, whatever the comparison does, while `dir_sel_i` is 00.
- R8: At every edge, `pin_o` is loaded with the new reference XOR `pol_i` (pol 0 gives an active-high pin, pol 1 an inverted pin).
- R9: A match sets `flag_o`, including while the reference is forced. The flag stays set until an edge with `flag_clr_i` high and no match. A match at the same edge as a clear leaves the flag set.
- R10: `irq_o` is registered at each edge as the new flag value AND `irq_en_i`.
- R11: While `dir_sel_i` is not 00, no match occurs and the reference holds, whatever the mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | CW | Timer counter value |
| upd_evt_i | input | 1 | Counter update event (preload transfer strobe) |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CW | Compare value to write |
| preload_en_i | input | 1 | 1: write waits for update event; 0: immediate |
| dir_sel_i | input | 2 | Channel direction; 00 selects output compare |
| mode_i | input | 3 | Reference action code |
| pol_i | input | 1 | Pin polarity; 1 inverts the reference |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the compare flag |
| irq_en_i | input | 1 | Interrupt enable |
| ref_o | output | 1 | Reference waveform, active high |
| pin_o | output | 1 | Pin output after polarity |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-local rules on every edge:
- a forced level appears at the next edge;
- the pin tracks reference XOR polarity;
- the reference holds under freeze codes and outside output direction;
- a match always leaves the flag set, and the flag stays set without a clear;
- the interrupt is never raised without the flag;
- a write with preload off lands at once, and the shadow value is stable between update events with preload on.

Other behaviour spans many cycles, and only the bench scenarios can show it: the timing of toggles across several counter periods, a match that is seen only once while the counter stays on the value, and a preload write that waits across a whole period. The bench scenarios also cover the flag still rising under forcing and a clear that meets a match at the same edge.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN   = 3'b000,
    OCM_SET      = 3'b001,
    OCM_CLEAR    = 3'b010,
    OCM_TOGGLE   = 3'b011,
    OCM_FORCE_LO = 3'b100,
    OCM_FORCE_HI = 3'b101,
    OCM_HOLD_6   = 3'b110,
    OCM_HOLD_7   = 3'b111
  } oc_mode_e;

  localparam logic [1:0] DIR_OUTPUT = 2'b00;

endpackage

// File: rtl/oc_shadow.sv
module oc_shadow #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          preload_i,
  input  logic          upd_i,
  output logic [CW-1:0] shadow_o
);

  logic [CW-1:0] buf_q;
  logic [CW-1:0] shadow_q;

  // Buffer always captures writes; shadow follows preload policy
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (preload_i) begin
        if (upd_i) shadow_q <= buf_q;
      end else if (wr_i) begin
        shadow_q <= wdata_i;
      end
    end
  end

  assign shadow_o = shadow_q;

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !preload_i) |=> (shadow_o == $past(wdata_i)));   // R2
  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (preload_i && !upd_i) |=> $stable(shadow_o));             // R3

endmodule

// File: rtl/oc_compare.sv
module oc_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] shadow_i,
  input  logic          out_mode_i,
  output logic          hit_o
);

  logic eq;
  logic eq_q;

  assign eq = (cnt_i == shadow_i);

  // Equality history; starts as "equal" so reset alone never matches
  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b1;
    else     eq_q <= eq;
  end

  assign hit_o = out_mode_i && eq && !eq_q;

  AST_HIT_ONCE: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);                                        // R4

endmodule

// File: rtl/oc_refgen.sv
module oc_refgen
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit_i,
  input  logic       out_mode_i,
  input  logic [2:0] mode_i,
  input  logic       pol_i,
  output logic       ref_o,
  output logic       pin_o
);

  logic ref_q;
  logic pin_q;
  logic ref_nxt;

  always_comb begin
    ref_nxt = ref_q;
    if (out_mode_i) begin
      case (oc_mode_e'(mode_i))
        OCM_SET:      if (hit_i) ref_nxt = 1'b1;
        OCM_CLEAR:    if (hit_i) ref_nxt = 1'b0;
        OCM_TOGGLE:   if (hit_i) ref_nxt = ~ref_q;
        OCM_FORCE_HI: ref_nxt = 1'b1;
        OCM_FORCE_LO: ref_nxt = 1'b0;
        default:      ref_nxt = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      pin_q <= pol_i;
    end else begin
      ref_q <= ref_nxt;
      pin_q <= ref_nxt ^ pol_i;
    end
  end

  assign ref_o = ref_q;
  assign pin_o = pin_q;

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (out_mode_i && mode_i == 3'b101) |=> ref_o);              // R7
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (out_mode_i && mode_i == 3'b100) |=> !ref_o);             // R7
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (rst)
    pin_o == (ref_o ^ $past(pol_i)));                         // R8
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_mode_i && (mode_i == 3'b000 || mode_i[2:1] == 2'b11))
      |=> $stable(ref_o));                                    // R6
  AST_INPUT_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_mode_i |=> $stable(ref_o));                          // R11

endmodule

// File: rtl/oc_flag.sv
module oc_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;
  logic irq_q;
  logic flag_nxt;

  // A match at the same edge as a clear wins
  assign flag_nxt = (flag_q && !clr_i) || hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt && irq_en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> flag_o);                                        // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);                           // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);                                        // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o);                                    // R10

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic          upd_evt_i,
  input  logic          cmp_wr_i,
  input  logic [CW-1:0] cmp_wdata_i,
  input  logic          preload_en_i,
  input  logic [1:0]    dir_sel_i,
  input  logic [2:0]    mode_i,
  input  logic          pol_i,
  input  logic          flag_clr_i,
  input  logic          irq_en_i,
  output logic          ref_o,
  output logic          pin_o,
  output logic          flag_o,
  output logic          irq_o
);

  logic [CW-1:0] shadow;
  logic          out_mode;
  logic          hit;

  assign out_mode = (dir_sel_i == DIR_OUTPUT);

  oc_shadow #(.CW(CW)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (cmp_wr_i),
    .wdata_i   (cmp_wdata_i),
    .preload_i (preload_en_i),
    .upd_i     (upd_evt_i),
    .shadow_o  (shadow)
  );

  oc_compare #(.CW(CW)) u_compare (
    .clk        (clk),
    .rst        (rst),
    .cnt_i      (cnt_i),
    .shadow_i   (shadow),
    .out_mode_i (out_mode),
    .hit_o      (hit)
  );

  oc_refgen u_refgen (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit),
    .out_mode_i (out_mode),
    .mode_i     (mode_i),
    .pol_i      (pol_i),
    .ref_o      (ref_o),
    .pin_o      (pin_o)
  );

  oc_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .hit_i    (hit),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

endmodule

// File: tb/oc_channel_test.sv
`timescale 1ns/1ps
module oc_channel_test;

  localparam int CW  = 16;
  localparam int PER = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt = '0;
  logic          upd = 1'b0;
  logic          wr = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic          pre = 1'b0;
  logic [1:0]    dir = 2'b00;
  logic [2:0]    mode = 3'b000;
  logic          pol = 1'b0;
  logic          clr = 1'b0;
  logic          ien = 1'b0;
  logic          ref_o, pin_o, flag_o, irq_o;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    live = 1'b0;

  // Behavioural reference state
  int m_shadow = 0, m_buf = 0;
  bit m_eqprev = 1, m_ref = 0, m_pin = 0, m_flag = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  oc_channel #(.CW(CW)) uut (
    .clk(clk), .rst(rst), .cnt_i(cnt), .upd_evt_i(upd), .cmp_wr_i(wr),
    .cmp_wdata_i(wdata), .preload_en_i(pre), .dir_sel_i(dir), .mode_i(mode),
    .pol_i(pol), .flag_clr_i(clr), .irq_en_i(ien),
    .ref_o(ref_o), .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_shadow = 0; m_buf = 0; m_eqprev = 1;
      m_ref = 0; m_pin = pol; m_flag = 0; m_irq = 0;
    end else begin
      bit eq, hit, nref, nflag;
      eq  = (int'(cnt) == m_shadow);
      hit = eq && !m_eqprev && (dir == 2'b00);
      nref = m_ref;
      if (dir == 2'b00) begin
        if (mode == 3'd5) nref = 1;
        else if (mode == 3'd4) nref = 0;
        else if (hit && mode == 3'd1) nref = 1;
        else if (hit && mode == 3'd2) nref = 0;
        else if (hit && mode == 3'd3) nref = !m_ref;
      end
      nflag = (m_flag && !clr) || hit;
      m_irq = nflag && ien;
      m_flag = nflag;
      m_ref = nref;
      m_pin = nref ^ pol;
      if (pre) begin
        if (upd) m_shadow = m_buf;
      end else if (wr) m_shadow = int'(wdata);
      if (wr) m_buf = int'(wdata);
      m_eqprev = eq;
    end
  end

  task automatic expect_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle
  always @(negedge clk) begin
    if (live && !rst) begin
      expect_bit(cur_req, "ref_o",  ref_o,  m_ref);
      expect_bit(cur_req, "pin_o",  pin_o,  m_pin);
      expect_bit(cur_req, "flag_o", flag_o, m_flag);
      expect_bit(cur_req, "irq_o",  irq_o,  m_irq);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt = (int'(cnt) == PER - 1) ? '0 : cnt + 1'b1;
      upd = (int'(cnt) == PER - 1);
      wr  = 1'b0;
      clr = 1'b0;
    end
  endtask

  task automatic write_cmp(int v);
    wr = 1'b1; wdata = CW'(v);
    tick(1);
  endtask

  task automatic go_to(int c);
    while (int'(cnt) != c) tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values still present before the first active edge
    expect_bit("R1", "ref_o",  ref_o,  1'b0);
    expect_bit("R1", "pin_o",  pin_o,  1'b0);
    expect_bit("R1", "flag_o", flag_o, 1'b0);
    expect_bit("R1", "irq_o",  irq_o,  1'b0);
    live = 1'b1;

    // R2: immediate load, set on match at 5
    cur_req = "R2"; mode = 3'd1;
    write_cmp(5);
    go_to(5); tick(1);
    expect_bit("R2", "ref after match at new value", ref_o, 1'b1);
    // R5: clear on match, then toggle over several periods
    cur_req = "R5"; mode = 3'd2; write_cmp(8);
    go_to(8); tick(1);
    expect_bit("R5", "ref cleared on match", ref_o, 1'b0);
    mode = 3'd3; tick(3 * PER);
    expect_bit("R5", "ref after three toggles", ref_o, 1'b1);

    // R4: counter parked on the compare value gives a single match
    cur_req = "R4";
    go_to(8);
    for (int i = 0; i < 6; i++) @(negedge clk);
    tick(PER);

    // R6: freeze codes hold through matches
    cur_req = "R6"; mode = 3'd0; tick(2 * PER);
    mode = 3'd6; tick(PER); mode = 3'd7; tick(PER);

    // R7 + R9: force high / low while matches still set the flag
    cur_req = "R7"; clr = 1'b1; tick(1);
    mode = 3'd5; tick(2);
    expect_bit("R7", "forced high", ref_o, 1'b1);
    clr = 1'b1; tick(1);
    cur_req = "R9"; tick(PER);
    expect_bit("R9", "flag set while forced", flag_o, 1'b1);
    cur_req = "R7"; mode = 3'd4; tick(2);
    expect_bit("R7", "forced low", ref_o, 1'b0);
    tick(PER);

    // R9: clear held across a match (set wins), then clear without match
    cur_req = "R9";
    for (int i = 0; i < PER; i++) begin clr = 1'b1; tick(1); end
    expect_bit("R9", "flag after clear held across match", flag_o, 1'b0);
    tick(PER);
    expect_bit("R9", "flag re-set by match", flag_o, 1'b1);

    // R8: polarity inversion in several modes
    cur_req = "R8"; pol = 1'b1; mode = 3'd3; tick(2 * PER + 3);
    mode = 3'd5; tick(2);
    expect_bit("R8", "inverted pin when forced high", pin_o, 1'b0);
    pol = 1'b0; tick(1);
    expect_bit("R8", "pin after polarity cleared", pin_o, 1'b1);

    // R3: preload holds new value until update event
    cur_req = "R3"; mode = 3'd3; pre = 1'b1;
    go_to(2); write_cmp(3);
    tick(2 * PER);
    go_to(PER - 1); write_cmp(6);
    tick(3 * PER);
    pre = 1'b0;

    // R10: interrupt enable gating
    cur_req = "R10"; ien = 1'b1; tick(PER);
    expect_bit("R10", "irq with flag and enable", irq_o, 1'b1);
    ien = 1'b0; tick(1);
    expect_bit("R10", "irq masked", irq_o, 1'b0);
    ien = 1'b1; clr = 1'b1; tick(PER);

    // R11: input direction, no match and reference holds
    cur_req = "R11"; clr = 1'b1; tick(1);
    dir = 2'b01; mode = 3'd4; tick(3);
    mode = 3'd5; tick(2 * PER);
    expect_bit("R11", "flag stays clear in input direction", flag_o, 1'b0);
    dir = 2'b10; mode = 3'd3; tick(PER);
    dir = 2'b00; tick(2 * PER);

    live = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule